// File: doc/BRIEF.md
# Protected-Mode Access Privilege Gate

This block rules on whether a single access may go ahead under the protected-mode privilege scheme. A caller presents one request per cycle. The request carries the current level, the level requested by the selector, and the level recorded in the descriptor. It also carries a real-mode flag, an access kind, the I/O privilege field, a flag saying whether the task state segment is the 32-bit variety, and a port number. The block answers with the effective level and a one-cycle verdict: either a grant strobe or a general-protection-fault strobe.

Most verdicts depend only on the request. One case needs more: a port instruction issued by code less privileged than the I/O privilege field, inside a task with a 32-bit task state segment. For that case the block fetches one byte of the per-task port permission bitmap from outside through a request/valid handshake and tests one bit of it. The requester is told to wait until that byte arrives. Descriptor fetch and task-state memory belong to neighbouring logic.

Top module: `priv_gate`

## Requirements
- R1: After reset, grant_o, fault_o and bm_req_o are low, req_ready_o is high and epl_o is 0.
- R2: On each accepted request (req_valid_i and req_ready_o both high at a rising edge), epl_o becomes the larger of cpl_i and rpl_i on the next edge, or 0 when real_mode_i is high. It holds that value until the next accepted request.
- R3: For kind_i = 2'b00 (segment data access), the edge after acceptance pulses grant_o for one cycle when the effective level is less than or equal to dpl_i. Otherwise it pulses fault_o. The two strobes are never high together.
- R4: For kind_i = 2'b01 (port instruction), 2'b10 or 2'b11 (other sensitive operations), the edge after acceptance pulses grant_o when the current level (0 in real mode) is less than or equal to iopl_i. No bitmap read is issued in this case.
- R5: When the current level exceeds iopl_i and tss32_i is low, every kind other than 2'b00 pulses fault_o on the edge after acceptance.
- R6: When the current level exceeds iopl_i and tss32_i is high, kinds 2'b10 and 2'b11 pulse fault_o on the edge after acceptance.
- R7: When the current level exceeds iopl_i, tss32_i is high and kind_i is 2'b01, the edge after acceptance raises bm_req_o with bm_addr_o equal to port_i shifted right by 3. Both hold steady until bm_valid_i is sampled high. No strobe is issued before then.
- R8: At the edge where bm_valid_i is sampled high during an outstanding read, bm_req_o drops. In the same cycle the block pulses fault_o if bit port_i[2:0] of bm_data_i is 1, and grant_o if that bit is 0.
- R9: req_ready_o is low from the edge that raises bm_req_o until the edge that ends the read. A request presented while it is low is discarded and changes neither epl_o nor the strobes.
- R10: bm_valid_i is ignored when no bitmap read is outstanding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_ready_o | output | 1 | Block can take a request this cycle |
| cpl_i | input | 2 | Current privilege level |
| rpl_i | input | 2 | Selector's requested privilege level |
| dpl_i | input | 2 | Descriptor privilege level |
| real_mode_i | input | 1 | Real mode: all levels count as 0 |
| kind_i | input | 2 | 00 segment data, 01 port instruction, 10/11 other sensitive op |
| iopl_i | input | 2 | I/O privilege field |
| tss32_i | input | 1 | Task uses a 32-bit task state segment |
| port_i | input | 16 | Port number for port instructions |
| epl_o | output | 2 | Effective privilege level of the last accepted request |
| grant_o | output | 1 | One-cycle access granted strobe |
| fault_o | output | 1 | One-cycle general protection fault strobe |
| bm_req_o | output | 1 | Bitmap byte read request, held until valid |
| bm_addr_o | output | 13 | Bitmap byte offset |
| bm_data_i | input | 8 | Bitmap byte returned |
| bm_valid_i | input | 1 | Bitmap byte valid |

## Verification
req_ready_o follows the block's state with no delay, so it is compared in the same cycle it is driven. epl_o, the immediate verdict strobes, bm_req_o and bm_addr_o each change at the first rising edge after acceptance. A bitmap verdict appears at the edge that samples bm_valid_i. The bench's reference model advances on the rising edge with the same edge-count for each result and is compared against every output at the following falling edge. Inputs change only at falling edges, so a request dropped while ready is low, or a stray valid with nothing outstanding, shows up at once as an output mismatch.

// File: rtl/priv_gate_pkg.sv
package priv_gate_pkg;

    typedef logic [1:0] lvl_t;

    typedef enum logic [1:0] {
        ACC_SEG      = 2'b00,
        ACC_PORT     = 2'b01,
        ACC_SENS     = 2'b10,
        ACC_SENS_ALT = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        VERD_GRANT  = 2'b00,
        VERD_FAULT  = 2'b01,
        VERD_LOOKUP = 2'b10
    } verdict_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } gate_state_e;

endpackage

// File: rtl/priv_level_resolve.sv
module priv_level_resolve
    import priv_gate_pkg::*;
(
    input  lvl_t cpl_i,
    input  lvl_t rpl_i,
    input  logic real_mode_i,
    output lvl_t cpl_eff_o,
    output lvl_t epl_o
);
    lvl_t lesser_priv;

    always_comb begin
        lesser_priv = (rpl_i > cpl_i) ? rpl_i : cpl_i;
        if (real_mode_i) begin
            cpl_eff_o = '0;
            epl_o     = '0;
        end else begin
            cpl_eff_o = cpl_i;
            epl_o     = lesser_priv;
        end
    end
endmodule

// File: rtl/priv_policy.sv
module priv_policy
    import priv_gate_pkg::*;
(
    input  lvl_t      epl_i,
    input  lvl_t      cpl_eff_i,
    input  lvl_t      dpl_i,
    input  acc_kind_e kind_i,
    input  lvl_t      iopl_i,
    input  logic      tss32_i,
    output verdict_e  verdict_o
);
    logic io_allowed;

    always_comb begin
        io_allowed = (cpl_eff_i <= iopl_i);
        unique case (kind_i)
            ACC_SEG: begin
                verdict_o = (epl_i <= dpl_i) ? VERD_GRANT : VERD_FAULT;
            end
            ACC_PORT: begin
                if (io_allowed)   verdict_o = VERD_GRANT;
                else if (tss32_i) verdict_o = VERD_LOOKUP;
                else              verdict_o = VERD_FAULT;
            end
            default: begin
                verdict_o = io_allowed ? VERD_GRANT : VERD_FAULT;
            end
        endcase
    end
endmodule

// File: rtl/iopm_bit_select.sv
module iopm_bit_select #(
    parameter int BYTE_W = 8,
    localparam int IDX_W = $clog2(BYTE_W)
) (
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic              deny_o
);
    logic [BYTE_W-1:0] hit;

    for (genvar g = 0; g < BYTE_W; g++) begin : g_bit
        assign hit[g] = byte_i[g] && (idx_i == IDX_W'(g));
    end

    assign deny_o = |hit;
endmodule

// File: rtl/priv_gate.sv
module priv_gate
    import priv_gate_pkg::*;
#(
    parameter int PORT_W = 16,
    parameter int BYTE_W = 8,
    localparam int IDX_W  = $clog2(BYTE_W),
    localparam int ADDR_W = PORT_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [1:0]        cpl_i,
    input  logic [1:0]        rpl_i,
    input  logic [1:0]        dpl_i,
    input  logic              real_mode_i,
    input  logic [1:0]        kind_i,
    input  logic [1:0]        iopl_i,
    input  logic              tss32_i,
    input  logic [PORT_W-1:0] port_i,
    output logic [1:0]        epl_o,
    output logic              grant_o,
    output logic              fault_o,
    output logic              bm_req_o,
    output logic [ADDR_W-1:0] bm_addr_o,
    input  logic [BYTE_W-1:0] bm_data_i,
    input  logic              bm_valid_i
);
    typedef struct packed {
        gate_state_e       st;
        logic              bm_req;
        logic [ADDR_W-1:0] addr;
        logic [IDX_W-1:0]  idx;
        logic              grant;
        logic              fault;
        lvl_t              epl;
    } gate_regs_t;

    gate_regs_t r_d, r_q;

    lvl_t     cpl_eff, epl_now;
    verdict_e verdict;
    logic     bit_deny;
    logic     accept;

    priv_level_resolve u_resolve (
        .cpl_i       (cpl_i),
        .rpl_i       (rpl_i),
        .real_mode_i (real_mode_i),
        .cpl_eff_o   (cpl_eff),
        .epl_o       (epl_now)
    );

    priv_policy u_policy (
        .epl_i     (epl_now),
        .cpl_eff_i (cpl_eff),
        .dpl_i     (dpl_i),
        .kind_i    (acc_kind_e'(kind_i)),
        .iopl_i    (iopl_i),
        .tss32_i   (tss32_i),
        .verdict_o (verdict)
    );

    iopm_bit_select #(.BYTE_W(BYTE_W)) u_bitsel (
        .byte_i (bm_data_i),
        .idx_i  (r_q.idx),
        .deny_o (bit_deny)
    );

    assign req_ready_o = (r_q.st == ST_IDLE);
    assign accept      = req_valid_i && req_ready_o;

    always_comb begin
        r_d       = r_q;
        r_d.grant = 1'b0;
        r_d.fault = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (accept) begin
                    r_d.epl = epl_now;
                    unique case (verdict)
                        VERD_GRANT: r_d.grant = 1'b1;
                        VERD_FAULT: r_d.fault = 1'b1;
                        default: begin
                            r_d.st     = ST_WAIT;
                            r_d.bm_req = 1'b1;
                            r_d.addr   = port_i[PORT_W-1:IDX_W];
                            r_d.idx    = port_i[IDX_W-1:0];
                        end
                    endcase
                end
            end
            default: begin
                if (bm_valid_i) begin
                    r_d.st     = ST_IDLE;
                    r_d.bm_req = 1'b0;
                    r_d.grant  = !bit_deny;
                    r_d.fault  = bit_deny;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, bm_req: 1'b0, addr: '0, idx: '0,
                     grant: 1'b0, fault: 1'b0, epl: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign epl_o     = r_q.epl;
    assign grant_o   = r_q.grant;
    assign fault_o   = r_q.fault;
    assign bm_req_o  = r_q.bm_req;
    assign bm_addr_o = r_q.addr;
endmodule

// File: rtl/priv_gate_chk.sv
module priv_gate_chk #(
    parameter int PORT_W = 16,
    parameter int BYTE_W = 8,
    localparam int ADDR_W = PORT_W - $clog2(BYTE_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid_i,
    input logic              req_ready_o,
    input logic [1:0]        cpl_i,
    input logic              real_mode_i,
    input logic [1:0]        kind_i,
    input logic [1:0]        iopl_i,
    input logic [1:0]        epl_o,
    input logic              grant_o,
    input logic              fault_o,
    input logic              bm_req_o,
    input logic [ADDR_W-1:0] bm_addr_o,
    input logic              bm_valid_i
);
    // R3: one verdict at a time
    assert_one_verdict_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_o && fault_o));

    // R2: effective level only moves on acceptance
    assert_epl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid_i && req_ready_o) |=> $stable(epl_o));

    // R4: privileged enough for sensitive ops means immediate grant
    assert_io_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o && kind_i != 2'b00 &&
         (real_mode_i || cpl_i <= iopl_i)) |=> (grant_o && !bm_req_o));

    // R7: read request and address held until data arrives
    assert_req_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bm_req_o && !bm_valid_i) |=> (bm_req_o && $stable(bm_addr_o)));

    // R8: data return ends the read with exactly one strobe
    assert_lookup_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bm_req_o && bm_valid_i) |=> (!bm_req_o && (grant_o != fault_o)));

    // R9: no new request while a read is outstanding
    assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bm_req_o |-> !req_ready_o);

    // R10: with nothing accepted and nothing outstanding, no strobe follows
    assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bm_req_o && !(req_valid_i && req_ready_o)) |=> (!grant_o && !fault_o));
endmodule

bind priv_gate priv_gate_chk #(.PORT_W(PORT_W), .BYTE_W(BYTE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .cpl_i       (cpl_i),
    .real_mode_i (real_mode_i),
    .kind_i      (kind_i),
    .iopl_i      (iopl_i),
    .epl_o       (epl_o),
    .grant_o     (grant_o),
    .fault_o     (fault_o),
    .bm_req_o    (bm_req_o),
    .bm_addr_o   (bm_addr_o),
    .bm_valid_i  (bm_valid_i)
);

// File: tb/priv_gate_bench.sv
module priv_gate_bench;
    localparam int PORT_W = 16;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 13;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid_i = 1'b0;
    logic              req_ready_o;
    logic [1:0]        cpl_i = '0, rpl_i = '0, dpl_i = '0, kind_i = '0, iopl_i = '0;
    logic              real_mode_i = 1'b0, tss32_i = 1'b0;
    logic [PORT_W-1:0] port_i = '0;
    logic [1:0]        epl_o;
    logic              grant_o, fault_o, bm_req_o;
    logic [ADDR_W-1:0] bm_addr_o;
    logic [BYTE_W-1:0] bm_data_i = '0;
    logic              bm_valid_i = 1'b0;

    priv_gate u_priv_gate (.*);

    always #10 clk = ~clk;   // 50 MHz

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 0;

    // reference model state
    bit       m_busy = 0;
    int       m_idx = 0;
    int       m_addr = 0;
    int       m_epl = 0;
    bit       m_grant = 0, m_fault = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // behavioural model, advanced on the same edge as the design
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_epl = 0; m_grant = 0; m_fault = 0; m_addr = 0; m_idx = 0;
        end else begin
            int cur, eff;
            m_grant = 0; m_fault = 0;
            if (m_busy) begin
                if (bm_valid_i) begin                        // R8
                    m_busy = 0;
                    if (bm_data_i[m_idx]) m_fault = 1; else m_grant = 1;
                end
            end else if (req_valid_i) begin                  // requests while busy dropped: R9
                cur = real_mode_i ? 0 : int'(cpl_i);
                eff = real_mode_i ? 0 : max2(int'(cpl_i), int'(rpl_i));
                m_epl = eff;                                 // R2
                if (kind_i == 2'b00) begin                   // R3
                    if (eff <= int'(dpl_i)) m_grant = 1; else m_fault = 1;
                end else if (cur <= int'(iopl_i)) begin      // R4
                    m_grant = 1;
                end else if (!tss32_i || kind_i != 2'b01) begin // R5 R6
                    m_fault = 1;
                end else begin                               // R7
                    m_busy = 1;
                    m_addr = int'(port_i) / 8;
                    m_idx  = int'(port_i) % 8;
                end
            end
        end
    end

    // compare all outputs each falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R9 ready", int'(req_ready_o), int'(!m_busy));
            chk("R2 epl", int'(epl_o), m_epl);
            chk("R3 R4 R5 R6 R8 grant", int'(grant_o), int'(m_grant));
            chk("R3 R5 R6 R8 fault", int'(fault_o), int'(m_fault));
            chk("R7 bm_req", int'(bm_req_o), int'(m_busy));
            if (m_busy) chk("R7 bm_addr", int'(bm_addr_o), m_addr);
        end
    end

    // bitmap memory responder with variable latency and stray valids (R10)
    int  lat = 1;
    bit  stray_en = 0;
    always @(negedge clk) begin
        if (bm_valid_i) begin
            bm_valid_i <= 1'b0;
        end else if (bm_req_o) begin
            if (lat == 0) begin
                bm_valid_i <= 1'b1;
                bm_data_i  <= BYTE_W'(int'(bm_addr_o) * 37) ^ 8'h5A;
                lat = $urandom_range(0, 3);
            end else begin
                lat--;
            end
        end else if (stray_en && ($urandom_range(0, 7) == 0)) begin
            bm_valid_i <= 1'b1;                               // R10: nothing outstanding
            bm_data_i  <= BYTE_W'($urandom);
        end
    end

    task automatic drive(input bit v, input int cpl, input int rpl, input int dpl,
                         input bit rm, input int kind, input int iopl, input bit t32,
                         input int port);
        @(negedge clk);
        req_valid_i <= v;
        cpl_i <= 2'(cpl); rpl_i <= 2'(rpl); dpl_i <= 2'(dpl);
        real_mode_i <= rm; kind_i <= 2'(kind); iopl_i <= 2'(iopl);
        tss32_i <= t32; port_i <= PORT_W'(port);
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                n_bad++;
                $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
                finish_run();
            end
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1 reset state, sampled before any request
        chk("R1 grant", int'(grant_o), 0);
        chk("R1 fault", int'(fault_o), 0);
        chk("R1 bm_req", int'(bm_req_o), 0);
        chk("R1 ready", int'(req_ready_o), 1);
        chk("R1 epl", int'(epl_o), 0);

        // directed: R2 effective level, R3 segment rule
        drive(1, 1, 3, 2, 0, 0, 0, 0, 0);   // epl 3 > dpl 2 -> fault
        drive(1, 2, 0, 2, 0, 0, 0, 0, 0);   // epl 2 -> grant
        drive(1, 3, 3, 0, 1, 0, 0, 0, 0);   // real mode -> epl 0 grant
        // R4 and R5
        drive(1, 1, 0, 0, 0, 1, 2, 0, 5);
        drive(1, 3, 0, 0, 0, 1, 1, 0, 5);
        // R6
        drive(1, 3, 0, 0, 0, 2, 0, 1, 5);
        drive(1, 3, 0, 0, 0, 3, 0, 1, 5);
        // R7 R8 bitmap, with a request during the wait (R9)
        drive(1, 3, 0, 0, 0, 1, 0, 1, 16'h03F9);
        drive(1, 0, 0, 3, 0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
        repeat (8) drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
        drive(1, 2, 1, 1, 0, 1, 1, 1, 16'hFFFF);
        repeat (8) drive(0, 0, 0, 0, 0, 0, 0, 0, 0);

        // random traffic with stray valids enabled (R10)
        stray_en = 1;
        for (int i = 0; i < 4000; i++) begin
            drive($urandom_range(0, 9) < 7,
                  int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                  int'($urandom_range(0, 3)), $urandom_range(0, 7) == 0,
                  int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                  $urandom_range(0, 1) == 1, int'($urandom_range(0, 65535)));
        end
        stray_en = 0;
        repeat (10) drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
        finish_run();
    end
endmodule